// File: doc/BRIEF.md
# Serial Master Clock Source Selector

This block produces the shift clock of a synchronous serial port when the port acts as master. A 3-bit source code chooses the clock. It can be a slow oscillator divided by 1, 2 or 4. It can be a fast oscillator divided by 1, 2 or 4. It can be a timer underflow pulse halved. One code switches the clock off so that the port can work as a slave with an external clock. A 2-bit format field sets the idle level of the serial clock and the edge on which data is sampled. The block drives a raw master clock, the formatted serial clock level, and one-cycle shift and sample strobes for a neighbouring shift register.

Each clock source arrives as a single-cycle pulse that is already synchronous to a faster system clock. A slow or fast oscillator pulse marks one half-period of that oscillator, so a pulse stream divided by N gives a master clock of N oscillator periods. A four-state machine controls source changes. OFF holds the clock idle while the code is 000. RUN divides the active source. FINISH lets a high pulse end on the old source's next toggle. HOLD keeps the clock low for one full period of the old source. The transitions are:
- OFF→RUN when a non-zero code appears.
- RUN→FINISH when the code changes while the clock is high.
- RUN→HOLD when the code changes while the clock is low.
- FINISH→HOLD on the old source's next toggle.
- HOLD→RUN, or HOLD→OFF for code 000, once the hold has elapsed.

Top module: `sclk_src_sel`

## Requirements
- R1: While reset is asserted and right after it, mclk is 0, sclk equals fmt[1], both strobes are 0 and the machine is in OFF.
- R2: With code 000 held, mclk stays 0 and no strobe is produced.
- R3: Codes 001, 010 and 011 make mclk toggle once every 1, 2 and 4 slow_edge pulses.
- R4: Code 100 makes mclk toggle on every tmr_uf pulse, so two underflows form one period.
- R5: Codes 101, 110 and 111 make mclk toggle once every 1, 2 and 4 fast_edge pulses.
- R6: A qualifying pulse changes mclk on the next clock edge; one register lies between them.
- R7: With fmt[1]=0 sclk equals mclk and idles low. With fmt[1]=1 sclk is the inverse of mclk and idles high.
- R8: With fmt[0]=0, sample_stb marks each mclk 0→1 change and shift_stb marks each 1→0 change. With fmt[0]=1 the two are swapped. Each strobe is high for one cycle and coincides with the new mclk level.
- R9: If the code changes while running, a high mclk stays high until the old source's next toggle. mclk is then held low for 2K old-source pulses, where K is the old divide ratio (1 for the timer). After that the new code takes effect with its divider cleared.
- R10: cfg_err is high exactly when sel is 101, 110 or 111 and FAST_HZ divided by 1, 2 or 4 exceeds LIMIT_HZ.
- R11: Leaving code 000 starts the new source on the next edge with its divider cleared, with no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than every source |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Source code |
| fmt | input | 2 | Format: bit 1 polarity (1 = idle high), bit 0 sampling on trailing edge |
| slow_edge | input | 1 | Pulse per slow-oscillator half-period |
| fast_edge | input | 1 | Pulse per fast-oscillator half-period |
| tmr_uf | input | 1 | Timer underflow pulse |
| mclk | output | 1 | Raw master clock, idle low |
| sclk | output | 1 | Formatted serial clock level |
| shift_stb | output | 1 | One-cycle strobe on the shifting edge |
| sample_stb | output | 1 | One-cycle strobe on the sampling edge |
| cfg_err | output | 1 | Fast-source rate above the limit |

## Verification
mclk and the strobe registers change one edge after the qualifying input, so they are due at the falling edge that follows the rising edge where the pulse was seen. sclk, the strobe selection and cfg_err follow their inputs within the same cycle. The bench drives inputs only after comparing at each falling edge. A behavioural model updates on the rising edge from the same inputs, so every output is compared in exactly the cycle its result is due, including across FINISH and HOLD.

// File: rtl/sclk_sel_pkg.sv
package sclk_sel_pkg;
    localparam int SEL_W   = 3;
    localparam int MAX_DIV = 4;
    localparam int CNT_W   = $clog2(2 * MAX_DIV);

    typedef enum logic [1:0] {
        ST_OFF,
        ST_RUN,
        ST_FINISH,
        ST_HOLD
    } sw_state_e;

    // source pulses per master-clock toggle for each code
    function automatic int toggle_div(input logic [SEL_W-1:0] code);
        case (code)
            3'd2, 3'd6: return 2;
            3'd3, 3'd7: return MAX_DIV;
            default:    return 1;
        endcase
    endfunction
endpackage

// File: rtl/sclk_event_mux.sv
module sclk_event_mux
    import sclk_sel_pkg::*;
(
    input  logic [SEL_W-1:0] code,
    input  logic             slow_edge,
    input  logic             fast_edge,
    input  logic             tmr_uf,
    output logic             ev,
    output logic [CNT_W-1:0] run_lim,
    output logic [CNT_W-1:0] hold_lim
);
    int k;

    always_comb begin
        unique case (code)
            3'd1, 3'd2, 3'd3: ev = slow_edge;
            3'd4:             ev = tmr_uf;
            3'd5, 3'd6, 3'd7: ev = fast_edge;
            default:          ev = 1'b0;
        endcase
        k        = toggle_div(code);
        run_lim  = CNT_W'(k - 1);
        hold_lim = CNT_W'(2 * k - 1);
    end
endmodule

// File: rtl/sclk_div_cnt.sv
module sclk_div_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ev,
    input  logic [W-1:0] lim,
    output logic         hit
);
    logic [W-1:0] cnt;

    assign hit = ev && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || hit)
            cnt <= '0;
        else if (ev)
            cnt <= cnt + 1'b1;
    end

    // count never passes the active limit
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim);
endmodule

// File: rtl/sclk_fmt_out.sv
module sclk_fmt_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lead_req,
    input  logic       trail_req,
    input  logic       mclk,
    input  logic [1:0] fmt,
    output logic       sclk,
    output logic       shift_stb,
    output logic       sample_stb
);
    logic lead_q;
    logic trail_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            lead_q  <= lead_req;
            trail_q <= trail_req;
        end
    end

    always_comb begin
        sclk       = mclk ^ fmt[1];
        sample_stb = fmt[0] ? trail_q : lead_q;
        shift_stb  = fmt[0] ? lead_q : trail_q;
    end

    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_stb && sample_stb));
endmodule

// File: rtl/sclk_src_sel.sv
module sclk_src_sel
    import sclk_sel_pkg::*;
#(
    parameter int FAST_HZ  = 4_000_000,
    parameter int LIMIT_HZ = 1_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       fmt,
    input  logic             slow_edge,
    input  logic             fast_edge,
    input  logic             tmr_uf,
    output logic             mclk,
    output logic             sclk,
    output logic             shift_stb,
    output logic             sample_stb,
    output logic             cfg_err
);
    localparam logic ERR_D1 = (FAST_HZ / 1) > LIMIT_HZ;
    localparam logic ERR_D2 = (FAST_HZ / 2) > LIMIT_HZ;
    localparam logic ERR_D4 = (FAST_HZ / MAX_DIV) > LIMIT_HZ;

    sw_state_e        state, st_n;
    logic [SEL_W-1:0] cur_sel, sel_n;
    logic             mclk_q, mclk_n;
    logic             clr, hit, ev;
    logic             lead_req, trail_req;
    logic [CNT_W-1:0] run_lim, hold_lim, lim;

    sclk_event_mux u_mux (
        .code      (cur_sel),
        .slow_edge (slow_edge),
        .fast_edge (fast_edge),
        .tmr_uf    (tmr_uf),
        .ev        (ev),
        .run_lim   (run_lim),
        .hold_lim  (hold_lim)
    );

    assign lim = (state == ST_HOLD) ? hold_lim : run_lim;

    sclk_div_cnt #(.W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .ev    (ev),
        .lim   (lim),
        .hit   (hit)
    );

    sclk_fmt_out u_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .lead_req   (lead_req),
        .trail_req  (trail_req),
        .mclk       (mclk_q),
        .fmt        (fmt),
        .sclk       (sclk),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            cur_sel <= '0;
            mclk_q  <= 1'b0;
        end else begin
            state   <= st_n;
            cur_sel <= sel_n;
            mclk_q  <= mclk_n;
        end
    end

    // next state and outputs
    always_comb begin
        st_n      = state;
        sel_n     = cur_sel;
        mclk_n    = mclk_q;
        clr       = 1'b0;
        lead_req  = 1'b0;
        trail_req = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (sel != '0) begin
                    sel_n = sel;
                    clr   = 1'b1;
                    st_n  = ST_RUN;
                end
            end
            ST_RUN: begin
                if (sel != cur_sel) begin
                    clr  = 1'b1;
                    st_n = mclk_q ? ST_FINISH : ST_HOLD;
                end else if (hit) begin
                    mclk_n    = ~mclk_q;
                    lead_req  = ~mclk_q;
                    trail_req = mclk_q;
                end
            end
            ST_FINISH: begin
                if (hit) begin
                    mclk_n    = 1'b0;
                    trail_req = 1'b1;
                    st_n      = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (hit) begin
                    sel_n = sel;
                    st_n  = (sel == '0) ? ST_OFF : ST_RUN;
                end
            end
            default: st_n = ST_OFF;
        endcase
    end

    always_comb begin
        unique case (sel)
            3'd5:    cfg_err = ERR_D1;
            3'd6:    cfg_err = ERR_D2;
            3'd7:    cfg_err = ERR_D4;
            default: cfg_err = 1'b0;
        endcase
    end

    assign mclk = mclk_q;

    assert_off_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !mclk_q);
    assert_hold_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !mclk_q);
    assert_edge_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mclk_q) |-> (shift_stb || sample_stb));
    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (sclk == fmt[1]));
endmodule

// File: tb/sim_sclk_src_sel.sv
`timescale 1ns/1ps
module sim_sclk_src_sel;
    localparam int FHZ = 4_000_000;
    localparam int LHZ = 1_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'd0;
    logic [1:0] fmt = 2'd0;
    logic       slow_edge = 1'b0, fast_edge = 1'b0, tmr_uf = 1'b0;
    logic       mclk, sclk, shift_stb, sample_stb, cfg_err;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    sclk_src_sel #(.FAST_HZ(FHZ), .LIMIT_HZ(LHZ)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .fmt(fmt),
        .slow_edge(slow_edge), .fast_edge(fast_edge), .tmr_uf(tmr_uf),
        .mclk(mclk), .sclk(sclk), .shift_stb(shift_stb),
        .sample_stb(sample_stb), .cfg_err(cfg_err)
    );

    // behavioural reference: 0 off, 1 run, 2 finish, 3 hold
    int m_st = 0, m_cur = 0, m_cnt = 0;
    bit m_mclk = 0, m_lead = 0, m_trail = 0;

    function automatic int kdiv(input int c);
        if (c == 2 || c == 6) return 2;
        if (c == 3 || c == 7) return 4;
        return 1;
    endfunction

    function automatic bit src_pulse(input int c);
        if (c >= 1 && c <= 3) return slow_edge;
        if (c == 4) return tmr_uf;
        if (c >= 5) return fast_edge;
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cur = 0; m_cnt = 0; m_mclk = 0; m_lead = 0; m_trail = 0;
        end else begin
            bit e, h;
            int lim;
            e = src_pulse(m_cur);
            lim = (m_st == 3) ? 2 * kdiv(m_cur) - 1 : kdiv(m_cur) - 1;
            h = e && (m_cnt == lim);
            m_lead = 0; m_trail = 0;
            if (m_st == 0) begin
                if (sel != 0) begin m_cur = int'(sel); m_cnt = 0; m_st = 1; end
            end else if (m_st == 1) begin
                if (int'(sel) != m_cur) begin m_cnt = 0; m_st = m_mclk ? 2 : 3; end
                else if (h) begin
                    m_cnt = 0; m_mclk = !m_mclk;
                    if (m_mclk) m_lead = 1; else m_trail = 1;
                end else if (e) m_cnt++;
            end else if (m_st == 2) begin
                if (h) begin m_cnt = 0; m_mclk = 0; m_trail = 1; m_st = 3; end
                else if (e) m_cnt++;
            end else begin
                if (h) begin m_cnt = 0; m_cur = int'(sel); m_st = (sel == 0) ? 0 : 1; end
                else if (e) m_cnt++;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        string t;
        bit e_err;
        if (m_st >= 2) t = "R9";
        else if (m_st == 0) t = "R2";
        else if (m_cur <= 3) t = "R3";
        else if (m_cur == 4) t = "R4";
        else t = "R5";
        check({t, " mclk"}, int'(mclk), int'(m_mclk));
        check("R7 sclk", int'(sclk), int'(m_mclk ^ fmt[1]));
        check("R8 sample_stb", int'(sample_stb), int'(fmt[0] ? m_trail : m_lead));
        check("R8 shift_stb", int'(shift_stb), int'(fmt[0] ? m_lead : m_trail));
        e_err = (sel == 5 && FHZ > LHZ) || (sel == 6 && FHZ / 2 > LHZ) ||
                (sel == 7 && FHZ / 4 > LHZ);
        check("R10 cfg_err", int'(cfg_err), int'(e_err));
    endtask

    task automatic next_cycle();
        @(negedge clk);
        cyc++;
        compare_all();
    endtask

    task automatic run_free(input int n);
        for (int i = 0; i < n; i++) begin
            next_cycle();
            slow_edge = (cyc % 6 == 0);
            fast_edge = (cyc % 2 == 0);
            tmr_uf    = (cyc % 5 == 0);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        finish_run();
    end

    initial begin
        int codes [14] = '{1, 2, 3, 4, 5, 6, 7, 0, 2, 7, 3, 5, 4, 0};
        int lens  [14] = '{60, 60, 80, 50, 40, 40, 60, 30, 9, 60, 7, 60, 50, 40};
        // R1: reset state, both polarities
        repeat (2) @(negedge clk);
        check("R1 mclk", int'(mclk), 0);
        check("R1 sclk", int'(sclk), 0);
        check("R1 strobes", int'(shift_stb | sample_stb), 0);
        fmt = 2'b10;
        #1 check("R1 sclk idle high", int'(sclk), 1);
        fmt = 2'b00;
        rst_n = 1'b1;
        // R2: code 000 with pulses present keeps the clock idle
        slow_edge = 1; fast_edge = 1; tmr_uf = 1;
        next_cycle(); next_cycle();
        check("R2 mclk stays low", int'(mclk), 0);
        slow_edge = 0; fast_edge = 0; tmr_uf = 0;
        sel = 3'd1;
        next_cycle();
        check("R11 running, no toggle yet", int'(mclk), 0);
        slow_edge = 1;
        next_cycle();
        check("R6 toggle one edge after pulse", int'(mclk), 1);
        check("R8 sample on leading edge", int'(sample_stb), 1);
        check("R8 no shift on leading edge", int'(shift_stb), 0);
        slow_edge = 0;
        next_cycle();
        check("R8 sample one cycle only", int'(sample_stb), 0);
        check("R6 mclk holds without pulse", int'(mclk), 1);
        for (int f = 0; f < 4; f++) begin
            fmt = 2'(f);
            foreach (codes[i]) begin
                sel = 3'(codes[i]);
                run_free(lens[i]);
            end
        end
        finish_run();
    end
endmodule